// File: doc/BRIEF.md
# Incremental PI Speed Regulator

This block closes the speed loop of a motor drive with a proportional–integral law written in velocity form. Every sample strobe brings a signed speed error. The block then forms the next control word from three terms: the previous control word, the present error weighted by the sum of the proportional and integral gains, and the previous error weighted by the proportional gain alone. Gains are unsigned fixed-point words with ten fraction bits. A tuning engine outside the block may rewrite them at any time. The block takes a copy only at the moment it accepts a strobe, so no single update ever mixes old and new gains.

The result is clamped to a symmetric limit that is set through a port, so a large error cannot make the integrator wrap. A synchronous clear wipes the stored output and the stored error so that the loop can restart from rest. Sequencing is done by a three-state machine. `IDLE` waits for a strobe and latches the error and the gains. `CALC` forms and registers the unclamped sum. `APPLY` clamps the sum, publishes it and moves the present error into the history. The transitions are IDLE→CALC on an accepted strobe, CALC→APPLY always, and APPLY→IDLE always. Clear forces any state back to IDLE.

Top module: `pi_speed_reg`

## Requirements
- R1: After reset `u_out` is 0, and the stored previous error is 0, so the first update uses only the present-error term.
- R2: Each update computes u = u_prev + ((kp+ki)·e) − (kp·e_prev), where kp and ki are unsigned gains with 10 fraction bits (1.0 = 1024), e and u are signed two's-complement integers, and u_prev is the previous published (clamped) output.
- R3: Each of the two products is shifted right by 10 on its own with an arithmetic shift before they are combined, so a negative product rounds toward minus infinity (for example −731100 gives −714).
- R4: The published output is clamped to the range [−lim_in, +lim_in]. An out-of-range sum gives the bound and never a wrapped value.
- R5: A high `clr` at a rising edge sets `u_out` and the stored previous error to 0 and returns the machine to IDLE. It takes priority over `strobe`.
- R6: `kp_in` and `ki_in` are sampled only at the edge where a strobe is accepted. Changes at any other time have no effect until the next accepted strobe.
- R7: A strobe that arrives while the machine is in CALC or APPLY is ignored. Its error value and gains take no part in any update.
- R8: `u_out` changes only at the second rising edge after the edge that accepts the strobe, and holds its value at every other edge except a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of output and error history |
| strobe | input | 1 | Sample strobe; accepted in IDLE |
| err_in | input | EW | Signed speed error sample |
| kp_in | input | GW | Proportional gain, unsigned, 10 fraction bits |
| ki_in | input | GW | Integral gain, unsigned, 10 fraction bits |
| lim_in | input | UW-1 | Magnitude of the output clamp |
| u_out | output | UW | Signed control output |

## Verification
The bench builds the block with its defaults: 16-bit error, 16-bit gains and 16-bit output, with 10 fraction bits. At these widths the full gain range of the tuner (kp up to 3.0, ki up to 10.0) multiplied by a near full-scale error gives products far above the output range. This lets the bench drive the clamp at both the tight limit it programs and at the full 32767 bound. The nominal gains (kp ≈ 0.14, ki = 7) applied to errors of both signs exercise the floor rounding of the arithmetic shift.

// File: rtl/pi_speed_pkg.sv
package pi_speed_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CALC  = 2'd1,
        ST_APPLY = 2'd2
    } pi_state_t;

endpackage

// File: rtl/pi_gain_hold.sv
module pi_gain_hold #(
    parameter int GW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [GW-1:0] kp_in,
    input  logic [GW-1:0] ki_in,
    output logic [GW:0]   k_now,
    output logic [GW-1:0] k_old
);

    // combined gain for the present error, plain gain for the past error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k_now <= '0;
            k_old <= '0;
        end else if (load) begin
            k_now <= {1'b0, kp_in} + {1'b0, ki_in};
            k_old <= kp_in;
        end
    end

    assert_gain_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(k_now) && $stable(k_old)));

endmodule

// File: rtl/pi_recur.sv
module pi_recur #(
    parameter int EW   = 16,
    parameter int GW   = 16,
    parameter int UW   = 16,
    parameter int FRAC = 10,
    localparam int PW  = EW + GW + 2,
    localparam int AW  = PW + 1
) (
    input  logic signed [EW-1:0] e_now,
    input  logic signed [EW-1:0] e_old,
    input  logic        [GW:0]   k_now,
    input  logic        [GW-1:0] k_old,
    input  logic signed [UW-1:0] u_prev,
    output logic signed [AW-1:0] acc
);

    logic signed [PW-1:0] e_now_x, e_old_x, k_now_x, k_old_x;
    logic signed [PW-1:0] p_now, p_old, s_now, s_old;
    logic signed [AW-1:0] s_now_a, s_old_a, u_a;

    always_comb begin
        e_now_x = $signed({{(PW-EW){e_now[EW-1]}}, e_now});
        e_old_x = $signed({{(PW-EW){e_old[EW-1]}}, e_old});
        k_now_x = $signed({{(PW-GW-1){1'b0}}, k_now});
        k_old_x = $signed({{(PW-GW){1'b0}}, k_old});
        p_now   = e_now_x * k_now_x;
        p_old   = e_old_x * k_old_x;
        // restore integer scaling, keeping the sign
        s_now   = p_now >>> FRAC;
        s_old   = p_old >>> FRAC;
        s_now_a = $signed({s_now[PW-1], s_now});
        s_old_a = $signed({s_old[PW-1], s_old});
        u_a     = $signed({{(AW-UW){u_prev[UW-1]}}, u_prev});
        acc     = u_a + s_now_a - s_old_a;
    end

endmodule

// File: rtl/pi_clamp.sv
module pi_clamp #(
    parameter int UW = 16,
    parameter int AW = 35
) (
    input  logic signed [AW-1:0] acc,
    input  logic        [UW-2:0] lim,
    output logic signed [UW-1:0] u_sat
);

    logic signed [AW-1:0] hi, lo;

    always_comb begin
        hi = $signed({{(AW-UW+1){1'b0}}, lim});
        lo = -hi;
        if (acc > hi)
            u_sat = $signed({1'b0, lim});
        else if (acc < lo)
            u_sat = -$signed({1'b0, lim});
        else
            u_sat = acc[UW-1:0];
    end

endmodule

// File: rtl/pi_speed_reg.sv
module pi_speed_reg
    import pi_speed_pkg::*;
#(
    parameter int EW   = 16,
    parameter int GW   = 16,
    parameter int UW   = 16,
    parameter int FRAC = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 strobe,
    input  logic signed [EW-1:0] err_in,
    input  logic        [GW-1:0] kp_in,
    input  logic        [GW-1:0] ki_in,
    input  logic        [UW-2:0] lim_in,
    output logic signed [UW-1:0] u_out
);

    localparam int PW = EW + GW + 2;
    localparam int AW = PW + 1;

    pi_state_t            state, state_nx;
    logic signed [EW-1:0] e_now_q, e_old_q;
    logic signed [AW-1:0] acc_c, acc_q;
    logic signed [UW-1:0] u_sat;
    logic        [GW:0]   k_now;
    logic        [GW-1:0] k_old;
    logic                 take;

    assign take = (state == ST_IDLE) && strobe && !clr;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (strobe) state_nx = ST_CALC;
            ST_CALC:  state_nx = ST_APPLY;
            ST_APPLY: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
        if (clr) state_nx = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_now_q <= '0;
            e_old_q <= '0;
            acc_q   <= '0;
            u_out   <= '0;
        end else if (clr) begin
            e_now_q <= '0;
            e_old_q <= '0;
            acc_q   <= '0;
            u_out   <= '0;
        end else begin
            unique case (state)
                ST_IDLE:  if (strobe) e_now_q <= err_in;
                ST_CALC:  acc_q <= acc_c;
                ST_APPLY: begin
                    u_out   <= u_sat;
                    e_old_q <= e_now_q;
                end
                default: ;
            endcase
        end
    end

    pi_gain_hold #(.GW(GW)) u_gain (
        .clk(clk), .rst_n(rst_n), .load(take),
        .kp_in(kp_in), .ki_in(ki_in),
        .k_now(k_now), .k_old(k_old)
    );

    pi_recur #(.EW(EW), .GW(GW), .UW(UW), .FRAC(FRAC)) u_recur (
        .e_now(e_now_q), .e_old(e_old_q),
        .k_now(k_now), .k_old(k_old),
        .u_prev(u_out), .acc(acc_c)
    );

    pi_clamp #(.UW(UW), .AW(AW)) u_clamp (
        .acc(acc_q), .lim(lim_in), .u_sat(u_sat)
    );

    assert_out_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_APPLY && !clr) |=>
            (u_out <= $signed({1'b0, $past(lim_in)}) &&
             u_out >= -$signed({1'b0, $past(lim_in)})));

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (u_out == '0 && state == ST_IDLE));

    assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && state != ST_APPLY) |=> $stable(u_out));

    assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && state != ST_IDLE) |=> ($stable(k_now) && $stable(e_now_q)));

    assert_calc_seq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && state == ST_CALC) |=> state == ST_APPLY);

endmodule

// File: tb/pi_speed_reg_bench.sv
module pi_speed_reg_bench;

    localparam int EW = 16, GW = 16, UW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic strobe = 1'b0;
    logic signed [EW-1:0] err_in = '0;
    logic [GW-1:0] kp_in = '0, ki_in = '0;
    logic [UW-2:0] lim_in = '0;
    logic signed [UW-1:0] u_out;

    int checks = 0, failures = 0;
    longint m_u = 0, m_e = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pi_speed_reg u_pi_speed_reg (
        .clk(clk), .rst_n(rst_n), .clr(clr), .strobe(strobe),
        .err_in(err_in), .kp_in(kp_in), .ki_in(ki_in),
        .lim_in(lim_in), .u_out(u_out)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint model(input longint e, input longint kp, input longint ki, input longint lim);
        longint p1, p2, s;
        p1 = (e * (kp + ki)) >>> 10;
        p2 = (m_e * kp) >>> 10;
        s = m_u + p1 - p2;
        if (s > lim) s = lim;
        if (s < -lim) s = -lim;
        return s;
    endfunction

    // one accepted sample; checks hold for two edges, then the new value
    task automatic sample(input int e, input string req);
        longint exp_u, old_u;
        old_u = u_out;
        exp_u = model(e, kp_in, ki_in, lim_in);
        @(negedge clk); strobe = 1'b1; err_in = EW'(e);
        @(negedge clk); strobe = 1'b0;
        @(negedge clk);
        check(u_out == old_u, "R8", u_out, old_u);
        @(negedge clk);
        check(u_out == exp_u, req, u_out, exp_u);
        m_u = exp_u; m_e = e;
    endtask

    task automatic t_reset();
        check(u_out == 0, "R1", u_out, 0);
        kp_in = 16'd143; ki_in = 16'd7168; lim_in = 15'd32767;
        sample(100, "R1");   // 7311*100 = 731100 -> 713
    endtask

    task automatic t_nominal();
        sample(-100, "R3");  // negative products round down
        sample(37, "R2");
        sample(-250, "R2");
        sample(0, "R2");
    endtask

    task automatic t_gain_change();
        kp_in = 16'd2048; ki_in = 16'd512;
        sample(55, "R6");
        kp_in = 16'd1; ki_in = 16'd1;
        sample(-9, "R2");
    endtask

    task automatic t_saturate();
        kp_in = 16'd3072; ki_in = 16'd10240; lim_in = 15'd1000;
        sample(30000, "R4");
        check(u_out == 1000, "R4", u_out, 1000);
        sample(-30000, "R4");
        sample(-30000, "R4");
        check(u_out == -1000, "R4", u_out, -1000);
        lim_in = 15'd32767;
        sample(32767, "R4");
        sample(32767, "R4");
        check(u_out == 32767, "R4", u_out, 32767);
    endtask

    task automatic t_clear();
        @(negedge clk); clr = 1'b1; strobe = 1'b1; err_in = 16'sd500;
        @(negedge clk); clr = 1'b0; strobe = 1'b0;
        check(u_out == 0, "R5", u_out, 0);
        repeat (3) @(negedge clk);
        check(u_out == 0, "R5", u_out, 0);
        m_u = 0; m_e = 0;
        kp_in = 16'd1024; ki_in = 16'd1024;
        sample(10, "R5");    // 2048*10>>10 = 20, previous error cleared
    endtask

    task automatic t_busy();
        longint exp_u;
        kp_in = 16'd512; ki_in = 16'd256;
        exp_u = model(40, 512, 256, 32767);
        @(negedge clk); strobe = 1'b1; err_in = 16'sd40;
        @(negedge clk); err_in = 16'sd9000; kp_in = 16'd9999; ki_in = 16'd9999;
        @(negedge clk); strobe = 1'b0;
        @(negedge clk);
        check(u_out == exp_u, "R7", u_out, exp_u);
        m_u = exp_u; m_e = 40;
        kp_in = 16'd100; ki_in = 16'd200;
        sample(-3, "R7");    // previous error must be 40, not 9000
    endtask

    task automatic t_idle_hold();
        longint held;
        held = u_out;
        kp_in = 16'd4000; ki_in = 16'd4000; err_in = 16'sd777;
        repeat (5) @(negedge clk);
        check(u_out == held, "R8", u_out, held);
        sample(1, "R6");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_nominal();
        t_gain_change();
        t_saturate();
        t_clear();
        t_busy();
        t_idle_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog actual=0 expected=1");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule